// File: doc/BRIEF.md
# Burst Address and Write Controller

This block is the control front end of a synchronous burst SRAM. On every rising clock edge it samples an external word address together with two active-low start strobes, one driven by the processor and one by the cache controller. When a start is accepted, the block loads the address and presets a 2-bit beat counter from the two address LSBs. After that, the low two bits of the array address are generated inside the block, and they move one beat in each cycle where the active-low advance input is low.

A run-time order input selects the beat sequence. Low gives linear order, which wraps inside the aligned 4-word block. High gives interleaved order. The block also turns the byte-write enable, the per-byte strobes and the global write into a registered per-byte write vector for the array. Both outputs are registered, so each appears one cycle after the inputs that produce it. A new external address can be loaded in every cycle, and no burst has to be used at all.

Top module: `burst_wr_ctl`

## Requirements
- R1: When the chip enable `sel_n` is low and either start strobe is low at an edge, `arr_addr` equals the sampled `addr_i` after that edge, and the beat count restarts at 0.
- R2: When both strobes are low in the same enabled cycle, the processor start wins. A processor-started cycle ignores the write controls, so `wr_bytes` is all zeros after that edge.
- R3: When `sel_n` is high, a low processor strobe is ignored: no address is loaded and the cycle behaves as if no strobe were present.
- R4: In a cycle with no accepted start or deselect, the address holds its value when `step_n` is high. It also holds when the block is idle, whatever `step_n` is.
- R5: With `order_i` low, an advance gives low bits = (start LSBs + beat) mod 4. Bits above bit 1 stay at their loaded value.
- R6: With `order_i` high, an advance gives low bits = start LSBs XOR beat. Bits above bit 1 stay at their loaded value.
- R7: In a write-eligible cycle with `gwr_n` high and `bwen_n` low, `wr_bytes[i]` = 1 exactly for each byte i whose `bsel_n[i]` is 0. With `bwen_n` high, `wr_bytes` is all zeros.
- R8: In a write-eligible cycle with `gwr_n` low, `wr_bytes` is all ones, whatever `bwen_n` and `bsel_n` are.
- R9: Write strobes appear only in selected cycles. Such a cycle is a cache-started cycle, or a cycle without a start while the block is active. After reset, or after a deselect (`sel_n` high with the cache strobe low), `wr_bytes` stays zero until the next start.
- R10: After reset, `arr_addr` is 0, `wr_bytes` is 0 and the block is idle.
- R11: Starts may arrive in consecutive cycles. Each new address appears on `arr_addr` in the cycle right after it is sampled, with no penalty cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | External word address |
| cpu_go_n | input | 1 | Processor start strobe, active low |
| cache_go_n | input | 1 | Cache-controller start strobe, active low |
| sel_n | input | 1 | Chip enable, active low |
| step_n | input | 1 | Beat advance, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| bwen_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | NB | Per-byte write select, active low |
| gwr_n | input | 1 | Global write, active low |
| arr_addr | output | AW | Registered array address |
| wr_bytes | output | NB | Registered per-byte write strobes, active high |

## Verification
The stimulus is random, with the strobes, the enable and the advance biased so that loads, holds, advances and deselects all occur often. Directed bursts run full 4-beat wraps from every start offset in both orders. Those bursts separate the linear sequence from the interleaved one, because the two differ only when the start LSBs are nonzero. Cycles with both strobes low, with the processor strobe low while disabled, and with a deselect in the middle of a burst separate the start priority and the selection tracking from plain address capture. Random mixes of global write, byte-write enable and byte selects show whether the global override hides the per-byte pattern.

// File: rtl/burst_wr_pkg.sv
package burst_wr_pkg;
  // Order of a beat inside the aligned 4-word block
  function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    logic [1:0] r;
    if (ilv) r = start ^ beat;
    else     r = start + beat;
    return r;
  endfunction

  typedef enum logic [1:0] {
    CYC_CONT  = 2'd0,
    CYC_CPU   = 2'd1,
    CYC_CACHE = 2'd2,
    CYC_DESEL = 2'd3
  } cyc_e;
endpackage

// File: rtl/bw_beat_ctr.sv
module bw_beat_ctr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] lsb_ld,
  input  logic       adv,
  output logic [1:0] start_q,
  output logic [1:0] beat_nx
);
  logic [1:0] beat_q, beat_d, start_d;

  always_comb begin
    beat_d  = beat_q;
    start_d = start_q;
    if (load) begin
      beat_d  = 2'd0;
      start_d = lsb_ld;
    end else if (adv) begin
      beat_d = beat_q + 2'd1;
    end
  end

  assign beat_nx = beat_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= 2'd0;
      start_q <= 2'd0;
    end else begin
      beat_q  <= beat_d;
      start_q <= start_d;
    end
  end

  // R4
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> (beat_q == $past(beat_q)));
endmodule

// File: rtl/bw_wr_mask.sv
module bw_wr_mask #(
  parameter int NB = 4
) (
  input  logic          bwen_n,
  input  logic [NB-1:0] bsel_n,
  input  logic          gwr_n,
  output logic [NB-1:0] mask
);
  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_byte
      assign mask[g] = !gwr_n || (!bwen_n && !bsel_n[g]);
    end
  endgenerate
endmodule

// File: rtl/burst_wr_ctl.sv
module burst_wr_ctl
  import burst_wr_pkg::*;
#(
  parameter int AW = 16,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          cpu_go_n,
  input  logic          cache_go_n,
  input  logic          sel_n,
  input  logic          step_n,
  input  logic          order_i,
  input  logic          bwen_n,
  input  logic [NB-1:0] bsel_n,
  input  logic          gwr_n,
  output logic [AW-1:0] arr_addr,
  output logic [NB-1:0] wr_bytes
);
  localparam int UW = AW - 2;

  cyc_e          kind;
  logic          load, adv;
  logic [1:0]    start_q, beat_nx;
  logic [NB-1:0] mask;
  logic [UW-1:0] up_q, up_d;
  logic          act_q, act_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [NB-1:0] wr_q, wr_d;

  always_comb begin
    if (!sel_n && !cpu_go_n)        kind = CYC_CPU;
    else if (!sel_n && !cache_go_n) kind = CYC_CACHE;
    else if (sel_n && !cache_go_n)  kind = CYC_DESEL;
    else                            kind = CYC_CONT;
  end

  assign load = (kind == CYC_CPU) || (kind == CYC_CACHE);
  assign adv  = (kind == CYC_CONT) && act_q && !step_n;

  bw_beat_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .lsb_ld  (addr_i[1:0]),
    .adv     (adv),
    .start_q (start_q),
    .beat_nx (beat_nx)
  );

  bw_wr_mask #(.NB(NB)) u_mask (
    .bwen_n (bwen_n),
    .bsel_n (bsel_n),
    .gwr_n  (gwr_n),
    .mask   (mask)
  );

  always_comb begin
    up_d   = up_q;
    act_d  = act_q;
    addr_d = addr_q;
    wr_d   = '0;
    unique case (kind)
      CYC_CPU: begin
        up_d   = addr_i[AW-1:2];
        act_d  = 1'b1;
        addr_d = addr_i;
      end
      CYC_CACHE: begin
        up_d   = addr_i[AW-1:2];
        act_d  = 1'b1;
        addr_d = addr_i;
        wr_d   = mask;
      end
      CYC_DESEL: act_d = 1'b0;
      default: begin
        if (adv) addr_d = {up_q, beat_lsb(start_q, beat_nx, order_i)};
        if (act_q) wr_d = mask;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q   <= '0;
      act_q  <= 1'b0;
      addr_q <= '0;
      wr_q   <= '0;
    end else begin
      up_q   <= up_d;
      act_q  <= act_d;
      addr_q <= addr_d;
      wr_q   <= wr_d;
    end
  end

  assign arr_addr = addr_q;
  assign wr_bytes = wr_q;

  // R1
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && (!cpu_go_n || !cache_go_n)) |=> (arr_addr == $past(addr_i)));
  // R2
  cpu_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !cpu_go_n) |=> (wr_bytes == '0));
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && cache_go_n && step_n) |=> $stable(arr_addr));
  // R8
  gwr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && cpu_go_n && !cache_go_n && !gwr_n) |=> (wr_bytes == {NB{1'b1}}));
  // R9
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && !cache_go_n) |=> (wr_bytes == '0));
  // R5 R6
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_go_n && cache_go_n) |=> (arr_addr[AW-1:2] == $past(arr_addr[AW-1:2])));
endmodule

// File: tb/tb_burst_wr_ctl.sv
`timescale 1ns/1ps
module tb_burst_wr_ctl;
  localparam int AW = 16;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          cpu_go_n, cache_go_n, sel_n, step_n, order_i, bwen_n, gwr_n;
  logic [NB-1:0] bsel_n;
  logic [AW-1:0] arr_addr;
  logic [NB-1:0] wr_bytes;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  logic [AW-3:0] m_up;
  logic [1:0]    m_l0, m_beat;
  bit            m_act;
  logic [AW-1:0] e_addr;
  logic [NB-1:0] e_wr;
  string         t_addr, t_wr;

  always #5 clk = ~clk;

  burst_wr_ctl #(.AW(AW), .NB(NB)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cpu_go_n(cpu_go_n),
    .cache_go_n(cache_go_n), .sel_n(sel_n), .step_n(step_n),
    .order_i(order_i), .bwen_n(bwen_n), .bsel_n(bsel_n), .gwr_n(gwr_n),
    .arr_addr(arr_addr), .wr_bytes(wr_bytes)
  );

  function automatic logic [1:0] ref_lsb(input logic [1:0] s, input logic [1:0] b,
                                         input bit ilv);
    return ilv ? (s ^ b) : 2'((s + b) & 2'b11);
  endfunction

  function automatic logic [NB-1:0] ref_mask(input bit g_n, input bit b_n,
                                             input logic [NB-1:0] s_n);
    if (!g_n) return {NB{1'b1}};
    if (!b_n) return ~s_n;
    return '0;
  endfunction

  task automatic check_out();
    n_chk++;
    if (arr_addr !== e_addr) begin
      n_bad++;
      $display("FAIL %s addr actual=%h expected=%h", t_addr, arr_addr, e_addr);
    end
    n_chk++;
    if (wr_bytes !== e_wr) begin
      n_bad++;
      $display("FAIL %s wr actual=%b expected=%b", t_wr, wr_bytes, e_wr);
    end
  endtask

  // drive one cycle at the falling edge, predict, check at next falling edge
  task automatic cyc(input logic [AW-1:0] a, input bit cpu, input bit cch, input bit sl,
                     input bit st, input bit ord, input bit bw, input logic [NB-1:0] bs,
                     input bit gw);
    bit was_act;
    addr_i = a; cpu_go_n = cpu; cache_go_n = cch; sel_n = sl; step_n = st;
    order_i = ord; bwen_n = bw; bsel_n = bs; gwr_n = gw;
    was_act = m_act;
    if (!sl && (!cpu || !cch)) begin
      m_up = a[AW-1:2]; m_l0 = a[1:0]; m_beat = 2'd0; m_act = 1;
      e_addr = a;
      t_addr = (!cpu && !cch) ? "R2/R1" : "R1/R11";
      if (!cpu) begin e_wr = '0; t_wr = "R2"; end
      else begin e_wr = ref_mask(gw, bw, bs); t_wr = !gw ? "R8" : "R7"; end
    end else if (sl && !cch) begin
      m_act = 0; e_wr = '0; t_addr = "R4"; t_wr = "R9";
    end else begin
      t_addr = (sl && !cpu) ? "R3" : "R4";
      if (m_act && !st) begin
        m_beat = m_beat + 2'd1;
        e_addr = {m_up, ref_lsb(m_l0, m_beat, ord)};
        t_addr = ord ? "R6" : "R5";
      end
      if (was_act) begin e_wr = ref_mask(gw, bw, bs); t_wr = !gw ? "R8" : "R7"; end
      else begin e_wr = '0; t_wr = "R9"; end
    end
    @(negedge clk);
    check_out();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; addr_i = '0; cpu_go_n = 1; cache_go_n = 1; sel_n = 1; step_n = 1;
    order_i = 1; bwen_n = 1; bsel_n = '1; gwr_n = 1;
    m_up = '0; m_l0 = '0; m_beat = '0; m_act = 0; e_addr = '0; e_wr = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    t_addr = "R10"; t_wr = "R10";
    check_out();
    rst_n = 1;
    @(negedge clk);
    // R9 idle: writes with no start produce nothing
    cyc(16'h1234, 1, 1, 0, 0, 1, 0, 4'b0000, 0);
    // directed full bursts, every start offset, both orders (R5 R6)
    for (int o = 0; o < 2; o++)
      for (int s = 0; s < 4; s++) begin
        cyc(16'hA5A0 | 16'(s), 1, 0, 0, 1, o[0], 1, '1, 1);
        for (int b = 0; b < 5; b++) cyc('0, 1, 1, 0, 0, o[0], 1, '1, 1);
      end
    // R2 both strobes with global write asserted
    cyc(16'h0F0F, 0, 0, 0, 1, 0, 0, 4'b0000, 0);
    // R3 processor strobe while disabled
    cyc(16'hFFFF, 0, 1, 1, 1, 0, 1, '1, 1);
    // R11 back-to-back loads
    for (int k = 0; k < 4; k++) cyc(16'(16'h3000 + k * 7), 1, 0, 0, 0, 1, 0, 4'(k), 1);
    // R9 deselect mid-burst then write attempts
    cyc(16'h0042, 1, 0, 0, 1, 0, 1, '1, 1);
    cyc('0, 1, 0, 1, 0, 0, 0, 4'b0101, 1);
    cyc('0, 1, 1, 0, 0, 0, 0, 4'b0000, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit cpu, cch, sl;
      r = $urandom_range(0, 99);
      cpu = !(r < 15);
      cch = !(r >= 10 && r < 35);
      sl  = ($urandom_range(0, 9) < 2);
      cyc(16'($urandom), cpu, cch, sl, $urandom_range(0, 3) == 0, 1'($urandom),
          $urandom_range(0, 2) == 0, 4'($urandom), $urandom_range(0, 4) != 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule